// File: doc/BRIEF.md
# Grayscale Nibble Pair Pixel Packer

This block turns an 8-bit grayscale frame buffer into the 4-bit-per-pixel word stream a grayscale LCD controller expects. Each output word carries the upper nibbles of two pixels. In the normal orientation the two pixels are vertically adjacent, because one controller page covers two display lines. In the rotated orientations the two pixels are horizontally adjacent.

A job is launched with a one-cycle `start` pulse. The pulse carries the row range, the line length in bytes, the orientation and the bus format. The packer fetches pixels through a read port with one cycle of latency. It offers each packed word on a valid/ready stream and pulses `done` once the last word has been taken. Two bus formats are supported. The 8-bit format uses a separate data/command line. The 9-bit format flags data in bit 8 of every word.

Top module: `nib_pair_packer`

## Requirements
- R1: Every packed word holds the upper nibble of the first pixel of the pair in bits [3:0] and the upper nibble of the second pixel in bits [7:4].
- R2: With `rotate`=0 the pair is pixel (x, y), which is the first, and pixel (x, y+1), which is the second. Pixel (x, y) sits at byte address y*lineLen+x. Words come out with x ascending from 0 to lineLen-1 inside a row pair. Row pairs step by 2 until the pair's first row exceeds `rowEnd`.
- R3: With `rotate`=0 the starting row is `rowStart` with bit 0 cleared.
- R4: With `rotate`=1 the pair is pixel (x, y), which is the first, and pixel (x+1, y), which is the second. x steps by 2 from 0 up to lineLen-2, for every row from `rowStart` to `rowEnd`. lineLen is even in this mode.
- R5: In the 9-bit format (`busMode`=1) bit 8 of every word is 1. In the 8-bit format (`busMode`=0) it is 0.
- R6: In the 8-bit format `dcOut` goes high in the cycle after `start` is accepted, before the first word. It stays high while every word is offered. In the 9-bit format it stays low.
- R7: The read port is used with one cycle of latency. `memRdData` returned in the cycle after `memRdEn` with `memAddr` is the byte at that address.
- R8: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` is held unchanged.
- R9: A `start` with `busMode` 2 or 3 raises `err` from the next cycle. It emits no words, issues no memory reads and gives no `done`. The next accepted start clears `err`.
- R10: `done` is a single-cycle pulse in the cycle after the last word is accepted. It appears at no other time.
- R11: A `start` pulse that arrives while a job is in progress is ignored, whatever its other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, taken only when idle |
| rotate | input | 1 | 0: vertical pairs, 1: horizontal pairs |
| busMode | input | 2 | 0: 8-bit words, 1: 9-bit words, 2/3: unsupported |
| rowStart | input | ROW_W | First row of the range |
| rowEnd | input | ROW_W | Last row of the range |
| lineLen | input | COL_W | Bytes per frame buffer line |
| memRdEn | output | 1 | Read request |
| memAddr | output | ADDR_W | Read byte address |
| memRdData | input | 8 | Read data, one cycle after the request |
| outValid | output | 1 | Packed word offered |
| outReady | input | 1 | Consumer accepts the word |
| outData | output | 9 | Packed word, bit 8 is the data flag in the 9-bit format |
| dcOut | output | 1 | Data/command line for the 8-bit format |
| done | output | 1 | Job finished pulse |
| err | output | 1 | Unsupported bus format was requested |

## Verification
The hardest case to reach is a second `start` pulse that lands in the middle of a job while the consumer is stalling. To get there, the stimulus fires an extra start with a different orientation and row range a few cycles into a job. At the same time it throttles `outReady` to two of every three cycles. The reference model keeps the word queue of the original job, so any word taken from the stray request shows up as a mismatch. A job with an odd `rowStart` checks that the first row is forced even. A job with an unsupported format checks the silent error path.

// File: rtl/nibpack_pkg.sv
package nibpack_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RDA   = 3'd1,
    S_RDB   = 3'd2,
    S_WAITB = 3'd3,
    S_OUT   = 3'd4,
    S_DONE  = 3'd5
  } pack_state_t;

  localparam logic [1:0] BUS_BYTE = 2'd0;
  localparam logic [1:0] BUS_NINE = 2'd1;

  typedef struct packed {
    logic load;
    logic rdA;
    logic rdB;
    logic capLo;
    logic capHi;
    logic stepCol;
    logic stepRow;
  } pack_strobe_t;

endpackage

// File: rtl/nibpack_ctrl.sv
module nibpack_ctrl
  import nibpack_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   busMode,
  input  logic         outReady,
  input  logic         colLast,
  input  logic         rowLast,
  output pack_strobe_t strb,
  output logic         outValid,
  output logic         dcOut,
  output logic         done,
  output logic         err,
  output logic         mode9
);

  pack_state_t state, stateNxt;
  logic modeOk;
  logic lastPair;

  assign modeOk   = (busMode == BUS_BYTE) || (busMode == BUS_NINE);
  assign lastPair = colLast && rowLast;
  assign outValid = (state == S_OUT);
  assign done     = (state == S_DONE);

  always_comb begin
    strb     = '0;
    stateNxt = state;
    case (state)
      S_IDLE: begin
        if (start && modeOk) begin
          strb.load = 1'b1;
          stateNxt  = S_RDA;
        end
      end
      S_RDA: begin
        strb.rdA = 1'b1;
        stateNxt = S_RDB;
      end
      S_RDB: begin
        strb.rdB   = 1'b1;
        strb.capLo = 1'b1;
        stateNxt   = S_WAITB;
      end
      S_WAITB: begin
        strb.capHi = 1'b1;
        stateNxt   = S_OUT;
      end
      S_OUT: begin
        if (outReady) begin
          if (lastPair) begin
            stateNxt = S_DONE;
          end else begin
            strb.stepRow = colLast;
            strb.stepCol = !colLast;
            stateNxt     = S_RDA;
          end
        end
      end
      S_DONE:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      dcOut <= 1'b0;
      err   <= 1'b0;
      mode9 <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == S_IDLE && start) begin
        err   <= !modeOk;
        dcOut <= (busMode == BUS_BYTE);
        mode9 <= (busMode == BUS_NINE);
      end else if (state == S_DONE) begin
        dcOut <= 1'b0;
      end
    end
  end

  // R8: a stalled word stays offered
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R10: done follows an accepted word
  a_r10_done_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(outValid && outReady));

  // R10: done lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: an error never coexists with an offered word
  a_r9_err_silent: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !outValid && !done);

endmodule

// File: rtl/nibpack_dp.sv
module nibpack_dp
  import nibpack_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pack_strobe_t      strb,
  input  logic              rotate,
  input  logic [ROW_W-1:0]  rowStart,
  input  logic [ROW_W-1:0]  rowEnd,
  input  logic [COL_W-1:0]  lineLen,
  input  logic [7:0]        memRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              colLast,
  output logic              rowLast,
  output logic [3:0]        pixLo,
  output logic [3:0]        pixHi
);

  localparam int ROW_X = ROW_W + 2;
  localparam int COL_X = COL_W + 2;

  logic              rotQ;
  logic [ROW_W-1:0]  rowCur, rowEndQ;
  logic [COL_W-1:0]  col, lenQ;
  logic [ADDR_W-1:0] rowBase;
  logic [ADDR_W-1:0] addrA, addrB, lenAddr;
  logic [ROW_W-1:0]  firstRow;
  logic [ROW_X-1:0]  rowNext;
  logic [COL_X-1:0]  colNext;

  assign firstRow = rotate ? rowStart : {rowStart[ROW_W-1:1], 1'b0};
  assign lenAddr  = ADDR_W'(lenQ);
  assign addrA    = rowBase + ADDR_W'(col);
  assign addrB    = rotQ ? addrA + ADDR_W'(1) : addrA + lenAddr;
  assign memRdEn  = strb.rdA || strb.rdB;
  assign memAddr  = strb.rdB ? addrB : addrA;

  assign rowNext = ROW_X'(rowCur) + (rotQ ? ROW_X'(1) : ROW_X'(2));
  assign colNext = COL_X'(col) + (rotQ ? COL_X'(2) : COL_X'(1));
  assign colLast = colNext >= COL_X'(lenQ);
  assign rowLast = rowNext > ROW_X'(rowEndQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rotQ    <= 1'b0;
      rowCur  <= '0;
      rowEndQ <= '0;
      col     <= '0;
      lenQ    <= '0;
      rowBase <= '0;
      pixLo   <= '0;
      pixHi   <= '0;
    end else begin
      if (strb.load) begin
        rotQ    <= rotate;
        rowCur  <= firstRow;
        rowEndQ <= rowEnd;
        lenQ    <= lineLen;
        col     <= '0;
        rowBase <= ADDR_W'(firstRow * lineLen);
      end
      if (strb.stepCol) begin
        col <= COL_W'(colNext);
      end
      if (strb.stepRow) begin
        col     <= '0;
        rowCur  <= ROW_W'(rowNext);
        rowBase <= rowBase + (rotQ ? lenAddr : (lenAddr << 1));
      end
      if (strb.capLo) pixLo <= memRdData[7:4];
      if (strb.capHi) pixHi <= memRdData[7:4];
    end
  end

  // R4: rotated column index stays even
  a_r4_even_col: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn && rotQ |-> !col[0]);

  // R7: the two reads of a pair are back to back
  a_r7_read_pair: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdA |=> memRdEn && $stable(col));

endmodule

// File: rtl/nib_pair_packer.sv
module nib_pair_packer
  import nibpack_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              rotate,
  input  logic [1:0]        busMode,
  input  logic [ROW_W-1:0]  rowStart,
  input  logic [ROW_W-1:0]  rowEnd,
  input  logic [COL_W-1:0]  lineLen,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic              outValid,
  input  logic              outReady,
  output logic [8:0]        outData,
  output logic              dcOut,
  output logic              done,
  output logic              err
);

  pack_strobe_t strb;
  logic colLast, rowLast, mode9;
  logic [3:0] pixLo, pixHi;

  nibpack_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .busMode  (busMode),
    .outReady (outReady),
    .colLast  (colLast),
    .rowLast  (rowLast),
    .strb     (strb),
    .outValid (outValid),
    .dcOut    (dcOut),
    .done     (done),
    .err      (err),
    .mode9    (mode9)
  );

  nibpack_dp #(
    .ADDR_W (ADDR_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rotate    (rotate),
    .rowStart  (rowStart),
    .rowEnd    (rowEnd),
    .lineLen   (lineLen),
    .memRdData (memRdData),
    .memRdEn   (memRdEn),
    .memAddr   (memAddr),
    .colLast   (colLast),
    .rowLast   (rowLast),
    .pixLo     (pixLo),
    .pixHi     (pixHi)
  );

  assign outData = {mode9, pixHi, pixLo};

  // R5/R6: exactly one of the two data markers is active on every word
  a_r5_flag_vs_dc: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outData[8] != dcOut);

  // R8: a stalled word keeps its value
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outData));

  // R7: reads never overlap an offered word
  a_r7_no_read_on_out: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !outValid);

endmodule

// File: tb/sim_nib_pair_packer.sv
module sim_nib_pair_packer;

  localparam int ADDR_W = 12;
  localparam int ROW_W  = 8;
  localparam int COL_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic rotate = 1'b0;
  logic [1:0] busMode = 2'd0;
  logic [ROW_W-1:0] rowStart = '0;
  logic [ROW_W-1:0] rowEnd = '0;
  logic [COL_W-1:0] lineLen = '0;
  logic memRdEn;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memRdData = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [8:0] outData;
  logic dcOut, done, err;

  always #10 clk = ~clk;

  nib_pair_packer #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .rotate(rotate), .busMode(busMode),
    .rowStart(rowStart), .rowEnd(rowEnd), .lineLen(lineLen),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .dcOut(dcOut), .done(done), .err(err)
  );

  logic [7:0] memArr [0:(1<<ADDR_W)-1];
  initial begin
    for (int a = 0; a < (1 << ADDR_W); a++) memArr[a] = 8'((a * 37 + 11) ^ (a >> 3));
  end
  // R7: one-cycle read latency model
  always @(posedge clk) if (memRdEn) memRdData <= memArr[memAddr];

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int readMode = 0;
  int readsSeen = 0;
  bit expDone = 0;
  bit jobDone = 0;
  bit holdPrev = 0;
  logic [8:0] holdData;
  bit mode8Job = 0;
  logic [8:0] expQ[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    outReady = (readMode == 0) ? 1'b1 : (cyc % 3 != 0);
    if (memRdEn) readsSeen++;
    if (rstN) begin
      if (expDone) begin
        chk(done == 1'b1, "R10 done pulse", int'(done), 1);
        expDone = 0;
        jobDone = 1;
      end else if (done) begin
        chk(1'b0, "R10 unexpected done", 1, 0);
      end
      if (holdPrev) begin
        chk(outValid && outData == holdData, "R8 hold while stalled", int'(outData), int'(holdData));
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R11/R9 unexpected word", int'(outData), 0);
        end else begin
          logic [8:0] e;
          e = expQ.pop_front();
          chk(outData == e, "R1 R2 R4 R5 word value", int'(outData), int'(e));
          chk(dcOut == mode8Job, "R6 dcOut during word", int'(dcOut), int'(mode8Job));
          if (expQ.size() == 0) expDone = 1;
        end
      end
      holdPrev = outValid && !outReady;
      holdData = outData;
    end
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic runJob(input bit rot, input logic [1:0] mode, input int sr, input int er,
                        input int len, input bit inject);
    int y0;
    expQ.delete();
    mode8Job = (mode == 2'd0);
    if (!rot) begin
      y0 = sr & ~1; // R3 start row forced even
      for (int y = y0; y <= er; y += 2)
        for (int x = 0; x < len; x++)
          expQ.push_back({mode == 2'd1, memArr[(y + 1) * len + x][7:4], memArr[y * len + x][7:4]});
    end else begin
      for (int y = sr; y <= er; y++)
        for (int x = 0; x < len; x += 2)
          expQ.push_back({mode == 2'd1, memArr[y * len + x + 1][7:4], memArr[y * len + x][7:4]});
    end
    jobDone = 0;
    @(negedge clk);
    rotate = rot; busMode = mode; rowStart = ROW_W'(sr); rowEnd = ROW_W'(er);
    lineLen = COL_W'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(dcOut == (mode == 2'd0), "R6 dcOut before first word", int'(dcOut), int'(mode == 2'd0));
    if (inject) begin
      repeat (4) @(negedge clk);
      rotate = ~rot; rowStart = 0; rowEnd = 1; busMode = 2'd2; start = 1'b1; // R11
      @(negedge clk);
      start = 1'b0;
    end
    while (!jobDone) @(negedge clk);
    chk(expQ.size() == 0, "R2 all words delivered", expQ.size(), 0);
    chk(err == 1'b0, "R9 err clear on good job", int'(err), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(outValid == 0 && done == 0 && err == 0 && dcOut == 0, "reset state",
        int'({outValid, done, err, dcOut}), 0);
    rstN = 1'b1;
    @(negedge clk);
    readMode = 0;
    runJob(1'b0, 2'd0, 2, 5, 6, 1'b0);   // R2 normal, 8-bit
    runJob(1'b0, 2'd1, 3, 4, 8, 1'b0);   // R3 odd start row, 9-bit
    runJob(1'b1, 2'd1, 1, 3, 8, 1'b0);   // R4 rotated, 9-bit
    readMode = 1;
    runJob(1'b1, 2'd0, 0, 2, 10, 1'b0);  // R8 stalls, rotated
    runJob(1'b0, 2'd1, 0, 1, 16, 1'b1);  // R11 stray start with stalls
    runJob(1'b0, 2'd0, 7, 7, 4, 1'b0);   // R3 single odd row
    // R9 unsupported bus format
    expQ.delete();
    readsSeen = 0;
    @(negedge clk);
    busMode = 2'd3; rowStart = 0; rowEnd = 2; lineLen = 4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1, "R9 err raised", int'(err), 1);
    repeat (20) @(negedge clk);
    chk(readsSeen == 0, "R9 no memory reads", readsSeen, 0);
    chk(err == 1'b1, "R9 err held", int'(err), 1);
    readMode = 0;
    runJob(1'b1, 2'd0, 4, 4, 2, 1'b0);   // R9 cleared by next job, R4 minimal
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule